// File: doc/BRIEF.md
# Programmable Multiplier-Resolution Watchdog

This block is a watchdog timer whose timeout is set by one byte-wide configuration register. The byte carries a 5-bit multiplier and a 2-bit resolution select. The resolution select picks a base period of 1/16 s, 1/4 s, 1 s or 4 s. The timeout is the multiplier times that base period. Every base period is derived from a single-cycle reference tick that arrives at 16 Hz.

Software arms the watchdog by writing the register. It keeps the watchdog from firing by pulsing the reload strobe before the count runs out. When the count does run out, the block raises a single-cycle expiry pulse, which can drive a processor reset or an interrupt. After that pulse the block stays idle until the next reload or register write.

The resolution prescaler runs freely and is never realigned to a reload. Because of this, the first step after a restart can arrive early. The real timeout is therefore between (M-1)·P and M·P reference ticks, where M is the multiplier and P is the number of ticks per step. This matches an accuracy of plus or minus one resolution period.

All configuration and reload pins are plain control signals. No data stream crosses the block boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `wdt_multres_top`

## Requirements
- R1: A write stores bits 6..2 of `cfg_data_i` as the multiplier (bit 2 is the LSB) and bits 1..0 as the resolution select. Bit 7 has no effect on behaviour.
- R2: Resolution codes 0, 1, 2 and 3 make one count step every 1, 4, 16 and 64 reference ticks respectively.
- R3: `expire_o` goes high in the clock cycle after the tick that completes the M-th step after a restart, where M is the multiplier. For register value 0x0E this takes 33 to 48 ticks.
- R4: The tick prescaler counts every reference tick, wrapping modulo 64, and is not cleared by a reload or a write. The first step after a restart may therefore come after fewer than P ticks.
- R5: A register write restarts the countdown from the newly written multiplier and resolution.
- R6: A pulse on `kick_i` restarts the countdown from the stored multiplier.
- R7: A multiplier of zero disables the watchdog. `expire_o` then stays low whatever the ticks do.
- R8: `expire_o` is high for exactly one cycle. After it, no further expiry occurs until a reload or a write.
- R9: A reload or write in the same cycle as a completing step wins, and no expiry occurs. A write in the same cycle as `kick_i` uses the written value.
- R10: After reset, the multiplier and resolution are zero, the block is idle, the prescaler is zero and `expire_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Single-cycle 16 Hz reference tick |
| cfg_wr_i | input | 1 | Configuration register write strobe |
| cfg_data_i | input | 8 | Configuration byte: multiplier [6:2], resolution [1:0] |
| kick_i | input | 1 | Reload strobe that restarts the countdown |
| expire_o | output | 1 | Single-cycle timeout pulse |

## Verification
The bench builds the block with its default parameters: a 5-bit multiplier, a 2-bit resolution and a factor of four between resolutions. It applies a reference tick every third clock. This keeps the longest timeout (31 steps of 64 ticks) within about six thousand cycles, so all four resolutions, both extreme multipliers and the full prescaler wrap can be reached. Reloads are placed on tick cycles on purpose, to exercise the same-cycle priority rules. The per-clock reference model tracks the free-running prescaler phase, so it also covers early first steps.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int unsigned WDT_MULT_W    = 5;
  localparam int unsigned WDT_RES_W     = 2;
  localparam int unsigned WDT_RES_SHIFT = 2;
  localparam int unsigned WDT_REG_W     = 8;

  // Prescaler width that spans the coarsest resolution.
  function automatic int unsigned pre_width(input int unsigned res_w,
                                            input int unsigned shift);
    int unsigned w;
    w = shift * ((1 << res_w) - 1);
    if (w == 0) w = 1;
    return w;
  endfunction

endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg #(
  parameter int unsigned REG_W  = 8,
  parameter int unsigned MULT_W = 5,
  parameter int unsigned RES_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  data_i,
  output logic [MULT_W-1:0] wr_mult_o,
  output logic [MULT_W-1:0] mult_o,
  output logic [RES_W-1:0]  res_o
);

  localparam int unsigned MULT_LSB = RES_W;
  localparam int unsigned MULT_MSB = RES_W + MULT_W - 1;

  logic [MULT_W-1:0] mult_q;
  logic [RES_W-1:0]  res_q;

  // The bits above MULT_MSB are never decoded.
  assign wr_mult_o = data_i[MULT_MSB:MULT_LSB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mult_q <= '0;
      res_q  <= '0;
    end else if (wr_i) begin
      mult_q <= data_i[MULT_MSB:MULT_LSB];
      res_q  <= data_i[RES_W-1:0];
    end
  end

  assign mult_o = mult_q;
  assign res_o  = res_q;

  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ($stable(mult_q) && $stable(res_q)));

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int unsigned RES_W     = 2,
  parameter int unsigned RES_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [RES_W-1:0] res_i,
  output logic             step_o
);

  localparam int unsigned NUM_RES = 1 << RES_W;
  localparam int unsigned PRE_W   = pre_width(RES_W, RES_SHIFT);

  logic [PRE_W-1:0]   pre_cnt;
  logic [NUM_RES-1:0] wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)
      pre_cnt <= '0;
    else if (tick_i)
      pre_cnt <= pre_cnt + 1'b1;
  end

  // One wrap flag per resolution. Code r completes a step when its
  // low r*RES_SHIFT prescaler bits are all ones.
  for (genvar r = 0; r < NUM_RES; r++) begin : g_wrap
    if (r == 0) begin : g_fine
      assign wrap[r] = 1'b1;
    end else begin : g_coarse
      assign wrap[r] = &pre_cnt[r*RES_SHIFT-1:0];
    end
  end

  assign step_o = tick_i & wrap[res_i];

  // R2
  step_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> tick_i);

  // R4
  pre_free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (pre_cnt == $past(pre_cnt) + 1'b1));

  // R4
  pre_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(pre_cnt));

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned MULT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [MULT_W-1:0] load_val_i,
  input  logic              step_i,
  output logic              expire_o
);

  localparam logic [MULT_W-1:0] LAST = MULT_W'(1);

  logic [MULT_W-1:0] remain;
  logic              armed;
  logic              expire_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain   <= '0;
      armed    <= 1'b0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (load_i) begin
        remain <= load_val_i;
        armed  <= |load_val_i;
      end else if (armed && step_i) begin
        if (remain == LAST) begin
          remain   <= '0;
          armed    <= 1'b0;
          expire_q <= 1'b1;
        end else begin
          remain <= remain - 1'b1;
        end
      end
    end
  end

  assign expire_o = expire_q;

  // R8
  one_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |=> !expire_q);

  // R8
  idle_after_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_q && !load_i) |-> !armed);

  // R7
  zero_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && load_val_i == '0) |=> (!armed && !expire_q));

  // R5
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (remain == $past(load_val_i) && !expire_q));

  // R3
  armed_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (remain != '0));

  // R9
  no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (remain <= $past(remain)));

endmodule

// File: rtl/wdt_multres_top.sv
module wdt_multres_top
  import wdt_pkg::*;
#(
  parameter int unsigned REG_W     = WDT_REG_W,
  parameter int unsigned MULT_W    = WDT_MULT_W,
  parameter int unsigned RES_W     = WDT_RES_W,
  parameter int unsigned RES_SHIFT = WDT_RES_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             cfg_wr_i,
  input  logic [REG_W-1:0] cfg_data_i,
  input  logic             kick_i,
  output logic             expire_o
);

  logic [MULT_W-1:0] wr_mult;
  logic [MULT_W-1:0] mult_q;
  logic [RES_W-1:0]  res_q;
  logic              step;
  logic              load;
  logic [MULT_W-1:0] load_val;

  wdt_cfg_reg #(
    .REG_W  (REG_W),
    .MULT_W (MULT_W),
    .RES_W  (RES_W)
  ) cfg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (cfg_wr_i),
    .data_i    (cfg_data_i),
    .wr_mult_o (wr_mult),
    .mult_o    (mult_q),
    .res_o     (res_q)
  );

  wdt_prescaler #(
    .RES_W     (RES_W),
    .RES_SHIFT (RES_SHIFT)
  ) pre_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .res_i  (res_q),
    .step_o (step)
  );

  // A write outranks a plain reload and supplies its own multiplier.
  assign load     = cfg_wr_i | kick_i;
  assign load_val = cfg_wr_i ? wr_mult : mult_q;

  wdt_countdown #(
    .MULT_W (MULT_W)
  ) cnt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (load_val),
    .step_i     (step),
    .expire_o   (expire_o)
  );

  // R9
  reload_blocks_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_i || kick_i) |=> !expire_o);

  // R6
  kick_uses_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_i && !cfg_wr_i && mult_q == '0) |=> !expire_o);

endmodule

// File: tb/wdt_multres_top_tb_top.sv
module wdt_multres_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 3;
  localparam int WDOG_LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i;
  logic       cfg_wr_i = 1'b0;
  logic [7:0] cfg_data_i = 8'h00;
  logic       kick_i = 1'b0;
  logic       expire_o;

  int    total = 0;
  int    bad = 0;
  int    cycles = 0;
  int    tick_phase = 0;
  string cur_req = "R10";

  // reference model state
  int m_pre = 0;
  int m_mult = 0;
  int m_res = 0;
  int m_remain = 0;
  bit m_armed = 1'b0;
  bit m_exp = 1'b0;

  wdt_multres_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .cfg_wr_i   (cfg_wr_i),
    .cfg_data_i (cfg_data_i),
    .kick_i     (kick_i),
    .expire_o   (expire_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  assign tick_i = rst_n && (tick_phase == TICK_DIV - 1);

  always @(posedge clk) begin
    tick_phase <= (tick_phase == TICK_DIV - 1) ? 0 : tick_phase + 1;
  end

  // Behavioural model, advanced on every clock edge.
  always @(posedge clk) begin
    int per;
    bit stp;
    bit nx;
    cycles++;
    if (!rst_n) begin
      m_pre = 0; m_mult = 0; m_res = 0; m_remain = 0; m_armed = 0; m_exp = 0;
    end else begin
      per = 4 ** m_res;
      stp = tick_i && ((m_pre % per) == per - 1);
      nx = 1'b0;
      if (cfg_wr_i) begin
        m_mult   = (cfg_data_i >> 2) & 31;
        m_res    = cfg_data_i & 3;
        m_remain = m_mult;
        m_armed  = (m_mult != 0);
      end else if (kick_i) begin
        m_remain = m_mult;
        m_armed  = (m_mult != 0);
      end else if (m_armed && stp) begin
        if (m_remain == 1) begin
          nx = 1'b1; m_armed = 1'b0; m_remain = 0;
        end else begin
          m_remain--;
        end
      end
      if (tick_i) m_pre = (m_pre + 1) % 64;
      m_exp = nx;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Compare against the model every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) check(expire_o === m_exp, cur_req, int'(expire_o), int'(m_exp));
  end

  always @(negedge clk) begin
    if (cycles > WDOG_LIMIT) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, WDOG_LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic write_cfg(input logic [7:0] v);
    cfg_wr_i = 1'b1; cfg_data_i = v;
    @(negedge clk);
    cfg_wr_i = 1'b0;
  endtask

  task automatic kick();
    kick_i = 1'b1;
    @(negedge clk);
    kick_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Counts ticks until expire_o is seen, or gives up after limit cycles.
  task automatic wait_expire(input int limit, output int ticks, output bit seen);
    ticks = 0; seen = 1'b0;
    for (int i = 0; i < limit; i++) begin
      if (expire_o) begin seen = 1'b1; break; end
      if (tick_i) ticks++;
      @(negedge clk);
    end
  endtask

  task automatic wait_tick();
    while (!tick_i) @(negedge clk);
  endtask

  initial begin
    int  tk;
    bit  sn;
    repeat (3) @(negedge clk);
    // R10: output low while and right after reset
    check(expire_o === 1'b0, "R10", int'(expire_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(expire_o === 1'b0, "R10", int'(expire_o), 0);
    idle(200);
    check(expire_o === 1'b0, "R10 idle after reset", int'(expire_o), 0);

    // R7: zero multiplier at every resolution never fires
    cur_req = "R7";
    for (int r = 0; r < 4; r++) begin
      write_cfg(8'(r));
      wait_expire(800, tk, sn);
      check(!sn, "R7 zero multiplier", int'(sn), 0);
    end

    // R3 / R1: 3 steps of 16 ticks
    cur_req = "R3";
    write_cfg(8'h0E);
    wait_expire(400, tk, sn);
    check(sn, "R3 expiry seen", int'(sn), 1);
    check(tk >= 33 && tk <= 48, "R3 tick window", tk, 48);

    // R8: nothing further after the pulse
    cur_req = "R8";
    @(negedge clk);
    check(expire_o === 1'b0, "R8 single cycle", int'(expire_o), 0);
    wait_expire(1500, tk, sn);
    check(!sn, "R8 stays idle", int'(sn), 0);

    // R1: bit 7 ignored
    cur_req = "R1";
    write_cfg(8'h8E);
    wait_expire(400, tk, sn);
    check(sn && tk >= 33 && tk <= 48, "R1 bit7 ignored", tk, 48);

    // R2: two steps at each resolution
    cur_req = "R2";
    for (int r = 0; r < 4; r++) begin
      write_cfg(8'((2 << 2) | r));
      wait_expire(600 * (r + 1), tk, sn);
      check(sn, "R2 expiry seen", int'(sn), 1);
      check(tk >= (4 ** r) + 1 && tk <= 2 * (4 ** r), "R2 tick window", tk, 2 * (4 ** r));
      idle(r * 7 + 1); // shift prescaler phase for R4
    end

    // R4: early first step possible; long coarse timeout
    cur_req = "R4";
    write_cfg(8'h7F);
    wait_expire(7000, tk, sn);
    check(sn && tk >= 30 * 64 + 1 && tk <= 31 * 64, "R4 max timeout", tk, 31 * 64);

    // R6: kicking holds it off
    cur_req = "R6";
    write_cfg(8'h10);
    for (int i = 0; i < 20; i++) begin
      idle(2 * TICK_DIV);
      kick();
    end
    check(m_armed, "R6 still armed", int'(m_armed), 1);
    wait_expire(100, tk, sn);
    check(sn && tk == 4, "R6 kick reload", tk, 4);

    // R5: rewrite mid count
    cur_req = "R5";
    write_cfg(8'h15);
    idle(20);
    write_cfg(8'h04);
    wait_expire(30, tk, sn);
    check(sn && tk == 1, "R5 rewrite", tk, 1);

    // R9: kick on the completing tick suppresses expiry
    cur_req = "R9";
    write_cfg(8'h04);
    wait_tick();
    kick();
    check(expire_o === 1'b0, "R9 reload wins", int'(expire_o), 0);
    // write with kick: written zero wins
    wait_tick();
    cfg_wr_i = 1'b1; kick_i = 1'b1; cfg_data_i = 8'h00;
    @(negedge clk);
    cfg_wr_i = 1'b0; kick_i = 1'b0;
    wait_expire(300, tk, sn);
    check(!sn, "R9 write beats kick", int'(sn), 0);

    // R6: kick with zero stored multiplier stays silent
    cur_req = "R6";
    kick();
    wait_expire(100, tk, sn);
    check(!sn, "R6 kick zero", int'(sn), 0);

    idle(5);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule